// File: doc/BRIEF.md
# Four-Channel Toggle-Mode PWM Controller

This block generates four independent pulse-width-modulated outputs. Software controls it through a small 32-bit register window. Each channel has three per-channel values: a 16-bit period, a 16-bit compare value and a down-counter. The counter moves once for each tick enable that the channel receives from an external prescaler. The block does not interpret the prescaler and clock-selector registers; it only stores them and drives their contents out so the prescaler can use them.

A channel produces a waveform only while both its enable bit and its toggle-mode bit are set. Otherwise its output sits at the idle level, which is the invert bit. While a channel runs, each period lasts period+1 ticks and the output is active for compare+1 of them. Two saturation rules apply: a zero period gives a constantly inactive output, and a compare value at or above the period gives a constantly active output. Each channel copies the period and compare registers into shadow copies when its counter reloads. A register write therefore never produces a truncated period. The interrupt and data registers are placeholders: they read as zero and ignore writes.

Top module: `quad_pwm_ctrl`

## Requirements
- R1: After reset, and again after any later reset, every register reads zero and `pwm_o`, `prescale_o` and `clksel_o` are all zero.
- R2: Register map:
  - 0x00 is the prescaler configuration, reflected on `prescale_o`.
  - 0x04 is the clock selector, reflected on `clksel_o`.
  - 0x08 is the control register.
  - For channel i, the period register is at 0x0C+12*i, the compare register at 0x10+12*i and the counter register at 0x14+12*i.
  - Read data appears on `bus_rdata` one clock after the request and is held until the next read.
- R3: The control field of channel 0 starts at bit 0, and the field of channel i>0 starts at bit 4+4*i. Within a field, bit 0 is enable, bit 2 is invert and bit 3 is toggle mode. A channel runs only when both enable and toggle mode are 1.
- R4: With a tick every cycle, a running channel repeats every period+1 ticks and is active for compare+1 of them.
- R5: A compare value greater than or equal to the period makes the output active for the whole period.
- R6: A period of 0 makes the output inactive for the whole period.
- R7: With invert set, the output is the complement of the waveform. A stopped channel drives its invert bit.
- R8: A write to a period or compare register with a value above 65535 stores 65535.
- R9: A running channel's counter register starts at 0. On each tick it loads the period if it is 0, and otherwise decrements. Writes to the counter register are ignored.
- R10: The following all read zero, and writes to them change nothing:
  - offsets 0x3C, 0x40 and 0x44 to 0x50;
  - unmapped offsets;
  - accesses whose address bits [1:0] are not zero.
- R11: Period and compare values written while a channel runs take effect only when its counter reloads from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside |
| tick_i | input | 4 | Per-channel count enable from the prescaler |
| bus_sel | input | 1 | Access request, one cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset within the 4 KiB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after a read request |
| prescale_o | output | 32 | Stored prescaler configuration |
| clksel_o | output | 32 | Stored clock-selector configuration |
| pwm_o | output | 4 | Channel outputs |

## Verification
The following internal faults all show up within one period of the affected channel:
- a wrong counter, which shifts the pulse;
- a wrong shadow copy, which changes the number of active ticks per period;
- a wrong control-field decode, which makes a channel run or idle at the wrong level.

Counting active cycles over two whole periods exposes duty errors regardless of phase. Gated single ticks make the counter register step one value at a time, so an early reload or a lost decrement shows up on the next read. A write that reaches the wrong register shows up on the following readback.

// File: rtl/quad_pwm_pkg.sv
package quad_pwm_pkg;
  localparam int unsigned NCH = 4;
  localparam int unsigned CW  = 16;
  localparam int unsigned DW  = 32;
  localparam int unsigned AW  = 12;

  localparam int unsigned OFF_PRE    = 'h00;
  localparam int unsigned OFF_SEL    = 'h04;
  localparam int unsigned OFF_CTL    = 'h08;
  localparam int unsigned OFF_CH0    = 'h0C;
  localparam int unsigned CH_STRIDE  = 'h0C;
  localparam int unsigned OFS_CMP    = 4;
  localparam int unsigned OFS_CNT    = 8;

  localparam int unsigned CTL_EN  = 0;
  localparam int unsigned CTL_INV = 2;
  localparam int unsigned CTL_TOG = 3;

  function automatic int unsigned ctl_base(input int unsigned ch);
    return (ch == 0) ? 0 : 4 + 4 * ch;
  endfunction
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import quad_pwm_pkg::*;
#(
  parameter int unsigned N  = NCH,
  parameter int unsigned W  = CW,
  parameter int unsigned D  = DW,
  parameter int unsigned A  = AW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [A-1:0]        bus_addr,
  input  logic [D-1:0]        bus_wdata,
  output logic [D-1:0]        bus_rdata,
  input  logic [N-1:0][W-1:0] cnt_i,
  output logic [N-1:0][W-1:0] per_o,
  output logic [N-1:0][W-1:0] cmp_o,
  output logic [N-1:0]        run_o,
  output logic [N-1:0]        inv_o,
  output logic [D-1:0]        pre_o,
  output logic [D-1:0]        sel_o
);
  localparam logic [W-1:0] SAT = {W{1'b1}};

  logic [D-1:0]        pre_q, pre_d, sel_q, sel_d, ctl_q, ctl_d, rdata_q, rd_d;
  logic [N-1:0][W-1:0] per_q, per_d, cmp_q, cmp_d;
  logic                aligned, wr_hit, rd_req;
  logic [W-1:0]        wclamp;

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr_hit  = bus_sel & bus_wr & aligned;
  assign rd_req  = bus_sel & ~bus_wr;
  assign wclamp  = (|bus_wdata[D-1:W]) ? SAT : bus_wdata[W-1:0];

  always_comb begin
    pre_d = pre_q;
    sel_d = sel_q;
    ctl_d = ctl_q;
    per_d = per_q;
    cmp_d = cmp_q;
    rd_d  = '0;
    if (wr_hit) begin
      if (bus_addr == A'(OFF_PRE)) pre_d = bus_wdata;
      if (bus_addr == A'(OFF_SEL)) sel_d = bus_wdata;
      if (bus_addr == A'(OFF_CTL)) ctl_d = bus_wdata;
      for (int c = 0; c < N; c++) begin
        if (bus_addr == A'(OFF_CH0 + CH_STRIDE * c))           per_d[c] = wclamp;
        if (bus_addr == A'(OFF_CH0 + CH_STRIDE * c + OFS_CMP)) cmp_d[c] = wclamp;
      end
    end
    if (aligned) begin
      if (bus_addr == A'(OFF_PRE)) rd_d = pre_q;
      if (bus_addr == A'(OFF_SEL)) rd_d = sel_q;
      if (bus_addr == A'(OFF_CTL)) rd_d = ctl_q;
      for (int c = 0; c < N; c++) begin
        if (bus_addr == A'(OFF_CH0 + CH_STRIDE * c))           rd_d = D'(per_q[c]);
        if (bus_addr == A'(OFF_CH0 + CH_STRIDE * c + OFS_CMP)) rd_d = D'(cmp_q[c]);
        if (bus_addr == A'(OFF_CH0 + CH_STRIDE * c + OFS_CNT)) rd_d = D'(cnt_i[c]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      sel_q   <= '0;
      ctl_q   <= '0;
      per_q   <= '0;
      cmp_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_hit) begin
        pre_q <= pre_d;
        sel_q <= sel_d;
        ctl_q <= ctl_d;
        per_q <= per_d;
        cmp_q <= cmp_d;
      end
      if (rd_req) rdata_q <= rd_d;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_field
    localparam int unsigned B = ctl_base(g);
    assign run_o[g] = ctl_q[B + CTL_EN] & ctl_q[B + CTL_TOG];
    assign inv_o[g] = ctl_q[B + CTL_INV];
  end

  assign per_o     = per_q;
  assign cmp_o     = cmp_q;
  assign pre_o     = pre_q;
  assign sel_o     = sel_q;
  assign bus_rdata = rdata_q;

  // R8: an oversized period write to channel 0 lands as the saturation value
  assert_clamp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == A'(OFF_CH0) && (|bus_wdata[D-1:W]))
      |=> per_q[0] == SAT);

  // R10: a misaligned read returns zero
  assert_misaligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr[1:0] != 2'b00) |=> bus_rdata == '0);

  // R10: a misaligned write leaves the control register untouched
  assert_nowrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr[1:0] != 2'b00) |=> $stable(ctl_q));
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         run_i,
  input  logic         inv_i,
  input  logic [W-1:0] per_i,
  input  logic [W-1:0] cmp_i,
  output logic [W-1:0] cnt_o,
  output logic         pwm_o
);
  logic [W-1:0] cnt_q, cnt_d, shp_q, shp_d, shc_q, shc_d;
  logic         out_q, out_d, act, reload;

  assign reload = run_i & tick_i & (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    shp_d = shp_q;
    shc_d = shc_q;
    if (!run_i) begin
      cnt_d = '0;
      shp_d = per_i;
      shc_d = cmp_i;
    end else if (tick_i) begin
      if (cnt_q == '0) begin
        cnt_d = per_i;
        shp_d = per_i;
        shc_d = cmp_i;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
    if (shp_q == '0)         act = 1'b0;
    else if (shc_q >= shp_q) act = 1'b1;
    else                     act = ((shp_q - cnt_q) <= shc_q);
    out_d = (run_i & act) ^ inv_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      shp_q <= '0;
      shc_q <= '0;
      out_q <= 1'b0;
    end else begin
      if (!run_i || tick_i) begin
        cnt_q <= cnt_d;
        shp_q <= shp_d;
        shc_q <= shc_d;
      end
      out_q <= out_d;
    end
  end

  assign cnt_o = cnt_q;
  assign pwm_o = out_q;

  // R7: a stopped channel drives its invert bit on the next cycle
  assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> pwm_o == $past(inv_i));

  // R6: zero period never produces an active level
  assert_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && shp_q == '0) |=> pwm_o == $past(inv_i));

  // R5: compare at or above period always produces an active level
  assert_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && shp_q != '0 && shc_q >= shp_q) |=> pwm_o == !$past(inv_i));

  // R9: a tick on a non-zero count decrements by one
  assert_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && tick_i && cnt_q != '0) |=> cnt_o == $past(cnt_q) - 1'b1);

  // R4: the count never exceeds the period in use
  assert_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= shp_q);

  // R11: the shadow period changes only on a reload while running
  assert_shadow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !reload) |=> $stable(shp_q) && $stable(shc_q));
endmodule

// File: rtl/quad_pwm_ctrl.sv
module quad_pwm_ctrl
  import quad_pwm_pkg::*;
#(
  parameter int unsigned N = NCH,
  parameter int unsigned W = CW,
  parameter int unsigned D = DW,
  parameter int unsigned A = AW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] tick_i,
  input  logic         bus_sel,
  input  logic         bus_wr,
  input  logic [A-1:0] bus_addr,
  input  logic [D-1:0] bus_wdata,
  output logic [D-1:0] bus_rdata,
  output logic [D-1:0] prescale_o,
  output logic [D-1:0] clksel_o,
  output logic [N-1:0] pwm_o
);
  logic [1:0]          rst_sync_q;
  logic                rst_int_n;
  logic [N-1:0][W-1:0] per_w, cmp_w, cnt_w;
  logic [N-1:0]        run_w, inv_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pwm_regs #(.N(N), .W(W), .D(D), .A(A)) regs_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cnt_i     (cnt_w),
    .per_o     (per_w),
    .cmp_o     (cmp_w),
    .run_o     (run_w),
    .inv_o     (inv_w),
    .pre_o     (prescale_o),
    .sel_o     (clksel_o)
  );

  for (genvar g = 0; g < N; g++) begin : g_chan
    pwm_chan #(.W(W)) chan_i (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .tick_i (tick_i[g]),
      .run_i  (run_w[g]),
      .inv_i  (inv_w[g]),
      .per_i  (per_w[g]),
      .cmp_i  (cmp_w[g]),
      .cnt_o  (cnt_w[g]),
      .pwm_o  (pwm_o[g])
    );
  end
endmodule

// File: tb/quad_pwm_ctrl_tb_top.sv
`timescale 1ns/1ps
module quad_pwm_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  tick = 4'h0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, pre_o, csel_o;
  logic [3:0]  pwm;
  int          n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  quad_pwm_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .bus_sel(sel), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .prescale_o(pre_o), .clksel_o(csel_o), .pwm_o(pwm)
  );

  typedef struct packed {
    logic [1:0]  ch;
    logic [15:0] per;
    logic [15:0] cmp;
    logic        inv;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{2'd0, 16'd4, 16'd1, 1'b0},
    '{2'd1, 16'd4, 16'd4, 1'b0},
    '{2'd2, 16'd4, 16'd9, 1'b0},
    '{2'd3, 16'd0, 16'd3, 1'b0},
    '{2'd0, 16'd7, 16'd0, 1'b0},
    '{2'd1, 16'd7, 16'd6, 1'b1},
    '{2'd2, 16'd3, 16'd0, 1'b1},
    '{2'd3, 16'd9, 16'd5, 1'b0},
    '{2'd0, 16'd0, 16'd0, 1'b1}
  };

  function automatic int fbase(input int ch);
    return (ch == 0) ? 0 : 4 + 4 * ch;
  endfunction

  function automatic int active_ticks(input int p, input int c);
    if (p == 0) return 0;
    if (c >= p) return p + 1;
    return c + 1;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic bwrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bread(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = a;
    @(negedge clk);
    sel = 1'b0;
    d = rdata;
  endtask

  task automatic pulse(input int ch);
    @(negedge clk);
    tick[ch] = 1'b1;
    @(negedge clk);
    tick[ch] = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin : main
    logic [31:0] r;
    do_reset();

    // R1: reset state
    check("R1 pwm", {28'h0, pwm}, 32'h0);
    check("R1 prescale", pre_o, 32'h0);
    bread(12'h008, r); check("R1 control", r, 32'h0);
    bread(12'h00C, r); check("R1 period0", r, 32'h0);
    bread(12'h014, r); check("R1 counter0", r, 32'h0);

    // R2: map and side outputs
    bwrite(12'h000, 32'h1234_5678);
    check("R2 prescale_o", pre_o, 32'h1234_5678);
    bread(12'h000, r); check("R2 prescale read", r, 32'h1234_5678);
    bwrite(12'h004, 32'h0000_4321);
    check("R2 clksel_o", csel_o, 32'h0000_4321);
    bwrite(12'h034, 32'h77);
    bread(12'h034, r); check("R2 compare3", r, 32'h77);
    bwrite(12'h024, 32'h1AB);
    bread(12'h024, r); check("R2 period2", r, 32'h1AB);

    // R8: saturation
    bwrite(12'h018, 32'h0001_0005);
    bread(12'h018, r); check("R8 period1 clamp", r, 32'hFFFF);
    bwrite(12'h01C, 32'hFFFF_FFFF);
    bread(12'h01C, r); check("R8 compare1 clamp", r, 32'hFFFF);
    bwrite(12'h01C, 32'h0000_FFFF);
    bread(12'h01C, r); check("R8 compare1 max", r, 32'hFFFF);

    // R10: placeholders, unmapped, misaligned
    foreach (VEC[i]) begin end
    bwrite(12'h03C, 32'hFFFF_FFFF);
    bread(12'h03C, r); check("R10 int enable", r, 32'h0);
    bwrite(12'h040, 32'hFFFF_FFFF);
    bread(12'h040, r); check("R10 int status", r, 32'h0);
    bwrite(12'h044, 32'hFFFF_FFFF);
    bread(12'h044, r); check("R10 data0", r, 32'h0);
    bwrite(12'h050, 32'hFFFF_FFFF);
    bread(12'h050, r); check("R10 data3", r, 32'h0);
    bread(12'h800, r); check("R10 unmapped", r, 32'h0);
    bwrite(12'h00C, 32'h11);
    bwrite(12'h00E, 32'h55);
    bread(12'h00C, r); check("R10 misaligned write", r, 32'h11);
    bread(12'h00D, r); check("R10 misaligned read", r, 32'h0);

    // Vector table: R3, R4, R5, R6, R7
    tick = 4'hF;
    for (int i = 0; i < 9; i++) begin
      int ch, p, c, hi, exp_hi, win;
      ch = VEC[i].ch; p = VEC[i].per; c = VEC[i].cmp;
      bwrite(12'(12 + 12 * ch), 32'(p));
      bwrite(12'(16 + 12 * ch), 32'(c));
      bwrite(12'h008, (32'h9 | (VEC[i].inv ? 32'h4 : 32'h0)) << fbase(ch));
      win = 2 * (p + 1);
      repeat (win + 4) @(negedge clk);
      hi = 0;
      for (int k = 0; k < win; k++) begin
        @(negedge clk);
        if (pwm[ch]) hi++;
      end
      exp_hi = active_ticks(p, c);
      if (VEC[i].inv) exp_hi = p + 1 - exp_hi;
      // R4 R5 R6 R7 duty over two periods
      check($sformatf("R4 vec%0d duty", i), 32'(hi), 32'(2 * exp_hi));
      check($sformatf("R3 vec%0d others idle", i), {28'h0, pwm & ~(4'h1 << ch)}, 32'h0);
      bwrite(12'h008, 32'h0);
      repeat (2) @(negedge clk);
      check($sformatf("R3 vec%0d stop", i), {31'h0, pwm[ch]}, 32'h0);
    end

    // R3: one of the two run bits missing keeps channel idle
    bwrite(12'h00C, 32'd3);
    bwrite(12'h010, 32'd1);
    bwrite(12'h008, 32'h1);
    begin
      int hi = 0;
      for (int k = 0; k < 12; k++) begin @(negedge clk); if (pwm[0]) hi++; end
      check("R3 enable only idle", 32'(hi), 32'h0);
    end
    bread(12'h014, r); check("R3 enable only counter", r, 32'h0);
    bwrite(12'h008, 32'h8);
    begin
      int hi = 0;
      for (int k = 0; k < 12; k++) begin @(negedge clk); if (pwm[0]) hi++; end
      check("R3 toggle only idle", 32'(hi), 32'h0);
    end
    // R7: stopped inverted channel idles high
    bwrite(12'h008, 32'hC);
    repeat (2) @(negedge clk);
    check("R7 stopped inverted", {31'h0, pwm[0]}, 32'h1);
    bwrite(12'h008, 32'h0);
    tick = 4'h0;

    // R9 and R11: gated ticks on channel 1
    bwrite(12'h018, 32'd5);
    bwrite(12'h01C, 32'd2);
    bwrite(12'h008, 32'h9 << 8);
    bread(12'h020, r); check("R9 counter start", r, 32'd0);
    pulse(1);
    bread(12'h020, r); check("R9 reload", r, 32'd5);
    pulse(1);
    bread(12'h020, r); check("R9 decrement", r, 32'd4);
    bwrite(12'h020, 32'd3);
    bread(12'h020, r); check("R9 counter write ignored", r, 32'd4);
    bwrite(12'h018, 32'd2);
    bread(12'h018, r); check("R11 period readback", r, 32'd2);
    pulse(1);
    bread(12'h020, r); check("R11 count keeps old period", r, 32'd3);
    check("R11 old compare active", {31'h0, pwm[1]}, 32'h1);
    pulse(1); pulse(1); pulse(1);
    bread(12'h020, r); check("R11 reached zero", r, 32'd0);
    check("R11 old period tail inactive", {31'h0, pwm[1]}, 32'h0);
    pulse(1);
    bread(12'h020, r); check("R11 reload new period", r, 32'd2);
    check("R11 new values saturate", {31'h0, pwm[1]}, 32'h1);

    // R1: reset while running
    do_reset();
    check("R1 pwm after reset", {28'h0, pwm}, 32'h0);
    check("R1 clksel after reset", csel_o, 32'h0);
    bread(12'h018, r); check("R1 period1 after reset", r, 32'h0);
    bread(12'h008, r); check("R1 control after reset", r, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule